// File: doc/BRIEF.md
# GPIO Bank with Interrupt Cause Logic

The block is a bank of general purpose I/O lines behind a small word-wide register bus. Each line is either an output, driven from an output register (or from a shared blink clock when blinking is enabled), or an input. Inputs pass through a two-flop synchroniser, and a per-line polarity bit can invert them. Software reads this adjusted value as the line's data-in.

Interrupts come from two sources per line. A level source is the adjusted input ANDed with a level-enable bit. An edge source is a sticky cause bit, ANDed with an edge-enable bit. The cause bit is set by any low-to-high change of the adjusted input, so the polarity bit picks whether rising or falling pin transitions are caught. The two sources are ORed per line, and each run of eight consecutive lines is ORed into one summary interrupt. Software acknowledges an edge by writing the cause word: every bit written as 0 clears, and every bit written as 1 keeps its value.

The bus accepts a write or a read in every cycle and never stalls, so there is no back-pressure at the block's edge. Writes land on the next clock edge. Read data is registered and appears one cycle after the request.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the edge cause, edge enable and level enable words read 0. The output word reads 0. All lines are inputs (direction word reads all ones, `pin_oe` all zero), and `irq_group` is 0.
- R2: The direction word sits at byte offset 0x04. A direction bit of 0 makes the line an output: `pin_oe` is high, and `pin_out` follows the output word (offset 0x00) from the clock edge that takes the write.
- R3: A read at a word-aligned offset returns the addressed word one cycle later. Offset 0x10 returns the synchronised pin level XOR the polarity word (offset 0x0C). The pin value is seen two clock edges after it changes. Accesses with nonzero address bits [1:0] are ignored.
- R4: A line's level source is its adjusted input ANDed with its bit of the level enable word (offset 0x1C). It reaches `irq_group` in the same cycle that the adjusted input changes.
- R5: A low-to-high change of a line's adjusted input sets its edge cause bit (offset 0x14) one clock edge after the adjusted value changes. This happens whatever the enable bits hold. The edge source is the cause bit ANDed with its edge enable bit (offset 0x18), and it stays asserted after the input falls again.
- R6: A write to the cause word clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: If a new edge and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R8: `irq_group[g]` is the OR of the per-line interrupts of lines 8g to 8g+7, and of no other line.
- R9: A high-to-low change of the adjusted input sets no cause bit. With polarity 1, a falling pin therefore sets the cause bit and a rising pin does not.
- R10: While a line's blink bit (offset 0x08) is set and the line is an output, `pin_out` toggles once every BLINK_DIV cycles. While the line is an input, or the blink bit is clear, `pin_out` follows the output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Read data, valid the cycle after `bus_rd` |
| pin_in | input | NUM_LINES | Asynchronous pin levels |
| pin_out | output | NUM_LINES | Value driven onto output lines |
| pin_oe | output | NUM_LINES | Output enable, high for output lines |
| irq_group | output | NUM_LINES/8 | Summary interrupts, one per group of eight lines |

## Verification
Each result has a fixed due time, and the bench samples at exactly that time. All checks happen at the falling clock edge, after the rising edges that produce the result.

| Result | Due |
|---|---|
| Register write, seen on `pin_out`/`pin_oe` | one rising edge after the write |
| Read data | one rising edge after the read request |
| Data-in and level interrupt, after a pin change | two rising edges later |
| Edge cause bit, after a pin change | three rising edges later |

The same-cycle collision case places the clearing write on exactly that third edge. Blink toggles are counted over a window whose length is a whole multiple of the prescaler.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Register index is byte address [4:2]; order fixes the byte offsets.
  typedef enum logic [2:0] {
    SEL_OUT   = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_POL   = 3'd3,
    SEL_DIN   = 3'd4,
    SEL_CAUSE = 3'd5,
    SEL_EMASK = 3'd6,
    SEL_LMASK = 3'd7
  } reg_sel_e;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_OUT   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_BLINK = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_POL   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIN   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_EMASK = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_LMASK = 5'h1C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int BLINK_DIV = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic phase
);
  localparam int CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      phase <= ~phase;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  adj_in,
  input  logic                  cause_wr,
  input  logic [NUM_LINES-1:0]  cause_wdata,
  input  logic [NUM_LINES-1:0]  edge_en,
  input  logic [NUM_LINES-1:0]  level_en,
  output logic [NUM_LINES-1:0]  cause,
  output logic [NUM_LINES-1:0]  edge_pulse,
  output logic [NUM_GROUPS-1:0] irq_group
);
  logic [NUM_LINES-1:0] adj_prev_q;
  logic [NUM_LINES-1:0] line_irq;

  always_ff @(posedge clk) begin
    if (rst) adj_prev_q <= '0;
    else     adj_prev_q <= adj_in;
  end

  // One rising detector on the polarity-adjusted value covers both senses.
  assign edge_pulse = adj_in & ~adj_prev_q;

  // New edges are ORed in after the clearing write, so an edge wins.
  always_ff @(posedge clk) begin
    if (rst)           cause <= '0;
    else if (cause_wr) cause <= (cause & cause_wdata) | edge_pulse;
    else               cause <= cause | edge_pulse;
  end

  assign line_irq = (cause & edge_en) | (adj_in & level_en);

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_group
      assign irq_group[g] = |line_irq[g*GROUP_SIZE +: GROUP_SIZE];
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int BLINK_DIV  = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [NUM_LINES-1:0]  bus_wdata,
  output logic [NUM_LINES-1:0]  bus_rdata,
  input  logic [NUM_LINES-1:0]  pin_in,
  output logic [NUM_LINES-1:0]  pin_out,
  output logic [NUM_LINES-1:0]  pin_oe,
  output logic [NUM_GROUPS-1:0] irq_group
);
  logic [NUM_LINES-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
  logic [NUM_LINES-1:0] pin_sync, adj_data, cause_q, edge_pulse;
  logic                 blink_phase;
  logic                 aligned;
  reg_sel_e             sel;
  logic                 wr_hit, rd_hit;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign sel     = reg_sel_e'(bus_addr[4:2]);
  assign wr_hit  = bus_wr && aligned;
  assign rd_hit  = bus_rd && aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr_hit) begin
      case (sel)
        SEL_OUT:   out_q   <= bus_wdata;
        SEL_DIR:   dir_q   <= bus_wdata;
        SEL_BLINK: blink_q <= bus_wdata;
        SEL_POL:   pol_q   <= bus_wdata;
        SEL_EMASK: emask_q <= bus_wdata;
        SEL_LMASK: lmask_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  gpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pin_in),
    .q_sync  (pin_sync)
  );

  assign adj_data = pin_sync ^ pol_q;

  gpio_irq_core #(
    .NUM_LINES  (NUM_LINES),
    .GROUP_SIZE (GROUP_SIZE),
    .NUM_GROUPS (NUM_GROUPS)
  ) u_core (
    .clk         (clk),
    .rst         (rst),
    .adj_in      (adj_data),
    .cause_wr    (wr_hit && (sel == SEL_CAUSE)),
    .cause_wdata (bus_wdata),
    .edge_en     (emask_q),
    .level_en    (lmask_q),
    .cause       (cause_q),
    .edge_pulse  (edge_pulse),
    .irq_group   (irq_group)
  );

  gpio_blink_gen #(.BLINK_DIV(BLINK_DIV)) u_blink (
    .clk   (clk),
    .rst   (rst),
    .phase (blink_phase)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_pin
      assign pin_out[i] = (blink_q[i] && !dir_q[i]) ? blink_phase : out_q[i];
    end
  endgenerate
  assign pin_oe = ~dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_hit) begin
      case (sel)
        SEL_OUT:   bus_rdata <= out_q;
        SEL_DIR:   bus_rdata <= dir_q;
        SEL_BLINK: bus_rdata <= blink_q;
        SEL_POL:   bus_rdata <= pol_q;
        SEL_DIN:   bus_rdata <= adj_data;
        SEL_CAUSE: bus_rdata <= cause_q;
        SEL_EMASK: bus_rdata <= emask_q;
        SEL_LMASK: bus_rdata <= lmask_q;
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [NUM_LINES-1:0]  bus_wdata,
  input logic [NUM_LINES-1:0]  bus_rdata,
  input logic [NUM_LINES-1:0]  pin_oe,
  input logic [NUM_GROUPS-1:0] irq_group,
  input logic [NUM_LINES-1:0]  cause_q,
  input logic [NUM_LINES-1:0]  edge_pulse,
  input logic [NUM_LINES-1:0]  emask_q,
  input logic [NUM_LINES-1:0]  lmask_q
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_group == '0 && pin_oe == '0));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DIR) |=> (pin_oe == ~$past(bus_wdata)));

  assert_dir_readback_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == OFS_DIR) |=> (bus_rdata == ~pin_oe));

  assert_no_enable_no_irq_R4: assert property (@(posedge clk) disable iff (rst)
    (emask_q == '0 && lmask_q == '0) |-> (irq_group == '0));

  assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == OFS_CAUSE) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  assert_cause_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CAUSE && edge_pulse == '0)
      |=> (cause_q == ($past(cause_q) & $past(bus_wdata))));

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_pulse != '0) |=> ((cause_q & $past(edge_pulse)) == $past(edge_pulse)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_LINES  (NUM_LINES),
  .NUM_GROUPS (NUM_GROUPS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_oe     (pin_oe),
  .irq_group  (irq_group),
  .cause_q    (cause_q),
  .edge_pulse (edge_pulse),
  .emask_q    (emask_q),
  .lmask_q    (lmask_q)
);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  localparam int N   = 32;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata, pin_out, pin_oe;
  logic [N-1:0]  pin_in = '0;
  logic [3:0]    irq_group;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NUM_LINES(N), .GROUP_SIZE(8), .BLINK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_group(irq_group)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic edges(input int k);
    repeat (k) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] d;
    logic [3:0]   exp_grp;
    int           toggles;
    logic         prev;

    edges(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(5'h14, d); check("R1 cause", d, '0);
    rd(5'h18, d); check("R1 edge enable", d, '0);
    rd(5'h1C, d); check("R1 level enable", d, '0);
    rd(5'h00, d); check("R1 output word", d, '0);
    rd(5'h04, d); check("R1 direction", d, '1);
    check("R1 pin_oe", pin_oe, '0);
    check("R1 irq_group", {28'd0, irq_group}, '0);

    // R2 direction and output driving; R3 readback and ignored misaligned write
    wr(5'h04, 32'hFFFF_0000);
    wr(5'h00, 32'h0000_A5C3);
    check("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    check("R2 pin_out", pin_out, 32'h0000_A5C3);
    wr(5'h01, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R3 out readback, misaligned write ignored", d, 32'h0000_A5C3);
    rd(5'h04, d); check("R3 dir readback", d, 32'hFFFF_0000);
    wr(5'h04, '1);
    wr(5'h00, '0);

    // R4 R8 R3: level source per line, group mapping, data-in latency
    for (int i = 0; i < N; i++) begin
      exp_grp = 4'b0001 << (i / 8);
      wr(5'h1C, 32'd1 << i);
      pin_in[i] = 1'b1;
      edges(1);
      check("R3 data-in not yet synchronised", {28'd0, irq_group}, '0);
      edges(1);
      check("R4 R8 level irq group", {28'd0, irq_group}, {28'd0, exp_grp});
      rd(5'h10, d); check("R3 data-in", d, 32'd1 << i);
      pin_in[i] = 1'b0;
      edges(2);
      check("R4 level irq drops", {28'd0, irq_group}, '0);
      wr(5'h1C, '0);
      wr(5'h14, '0);
    end

    // R5 R6 R8: edge cause per line, sticky, acknowledged by inverse mask
    for (int i = 0; i < N; i++) begin
      exp_grp = 4'b0001 << (i / 8);
      wr(5'h18, 32'd1 << i);
      pin_in[i] = 1'b1;
      edges(2);
      check("R5 cause not yet set", {28'd0, irq_group}, '0);
      edges(1);
      check("R5 R8 edge irq group", {28'd0, irq_group}, {28'd0, exp_grp});
      pin_in[i] = 1'b0;
      edges(3);
      check("R5 edge irq sticky", {28'd0, irq_group}, {28'd0, exp_grp});
      wr(5'h14, ~(32'd1 << i));
      check("R6 acknowledge", {28'd0, irq_group}, '0);
      wr(5'h18, '0);
    end

    // R6 partial clear keeps bits written as 1
    pin_in = 32'h0000_0208;
    edges(3);
    rd(5'h14, d); check("R5 cause latched without enable", d, 32'h0000_0208);
    wr(5'h14, ~32'h0000_0008);
    rd(5'h14, d); check("R6 partial clear", d, 32'h0000_0200);
    pin_in = '0;
    edges(3);
    wr(5'h14, '0);

    // R9 falling with polarity 0 sets nothing; polarity 1 catches falling
    pin_in[5] = 1'b1;
    edges(3);
    wr(5'h14, '0);
    pin_in[5] = 1'b0;
    edges(3);
    rd(5'h14, d); check("R9 falling pin, polarity 0", d, '0);
    pin_in[5] = 1'b1;
    edges(3);
    wr(5'h0C, 32'd1 << 5);
    edges(2);
    wr(5'h14, '0);
    rd(5'h10, d); check("R3 data-in inverted", d, '0);
    pin_in[5] = 1'b0;
    edges(3);
    rd(5'h14, d); check("R9 falling pin, polarity 1", d, 32'd1 << 5);
    wr(5'h14, '0);
    pin_in[5] = 1'b1;
    edges(3);
    rd(5'h14, d); check("R9 rising pin, polarity 1", d, '0);
    wr(5'h0C, '0);
    pin_in[5] = 1'b0;
    edges(3);
    wr(5'h14, '0);

    // R7 new edge and clearing write in the same cycle
    pin_in[1] = 1'b1;
    edges(3);
    pin_in[7] = 1'b1;
    edges(2);
    wr(5'h14, '0);
    rd(5'h14, d); check("R7 edge wins over clear", d, 32'd1 << 7);
    pin_in = '0;
    edges(3);
    wr(5'h14, '0);

    // R10 blink
    wr(5'h04, 32'hFFFF_FFFC);
    wr(5'h00, 32'h0000_0002);
    wr(5'h08, 32'h0000_0005);
    toggles = 0;
    prev = pin_out[0];
    for (int c = 0; c < 4 * DIV; c++) begin
      edges(1);
      if (pin_out[0] != prev) toggles++;
      prev = pin_out[0];
      check("R10 non-blinking output steady", {31'd0, pin_out[1]}, 32'd1);
      check("R10 blinking input follows word", {31'd0, pin_out[2]}, 32'd0);
    end
    check("R10 blink toggle count", toggles, 4);
    wr(5'h08, '0);
    check("R10 blink off follows word", {31'd0, pin_out[0]}, 32'd0);

    finished = 1;
    finish_run();
  end
endmodule